// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block is a timer peripheral with three independent 16-bit down counters. Software reaches it through a byte-wide bus with a 2-bit address. Addresses 0, 1 and 2 reach the count registers of channels 0, 1 and 2. Address 3 accepts control bytes only. A control byte picks a channel and sets how its 16-bit count is split across byte accesses, or it freezes the live count so that software can read a stable snapshot while counting goes on. Each channel has a tick input, which is its count clock enable, and one waveform output. Three waveforms are available: a one-time terminal-count flag, a periodic one-tick strobe and a square wave. Each has a period of N ticks for a loaded count N.

Each channel is built around a four-state machine. ST_IDLE waits for a count after reset or after a control byte. ST_HALF means the low byte of a two-byte count has arrived and the high byte is pending. ST_ARM means a complete count is held, and the next tick copies it into the counter. ST_COUNT means the counter runs. The transitions are named as follows. cfg_wr goes from any state to ST_IDLE. lo_wr goes from ST_IDLE or ST_COUNT to ST_HALF, and it applies when the pattern is low-then-high and the write pointer is on the low byte. done_wr goes from any state to ST_ARM when a write completes the count. first_tick goes from ST_ARM to ST_COUNT.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every output is low, every count reads 0 and every channel uses low-then-high access.
- R2: Control byte layout. Bits [7:6] are the channel (values 0 to 2, and 3 is ignored). Bits [5:4] are the access pattern: 00 freeze, 01 low byte only, 10 high byte only, 11 low then high. Bits [2:1] give the waveform: 10 is the strobe, 11 is the square wave, and any other value is terminal count. Bits 3 and 0 are ignored, so counting is always binary.
- R3: With low-only access a data write sets the count to {0, byte}. With high-only access it sets {byte, 0}. With low-then-high the first write is the low byte and the second is the high byte. After a control byte the counter holds its value until the whole count has been written.
- R4: The first tick after a complete count copies it into the counter. After that each tick lowers it by one. Without a tick and without a bus write, the count and the output stay unchanged.
- R5: Terminal-count waveform: the output goes low at the control byte and at every count write. With count N, it goes high on the Nth tick after the load tick and stays high.
- R6: Strobe waveform: the output is high after the control byte. When the counter is at 1, a tick drives it low for exactly one tick and reloads N, giving a period of N ticks.
- R7: Square wave with count N: the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, starting high. While it runs, the readable count is the remainder of the current half.
- R8: A loaded count of 0 acts as 65536.
- R9: A freeze command (bits [5:4]=00) captures the count as it stands before that clock edge. Reads return the captured value until all bytes of the access pattern have been read, and then reads follow the live count again. A second freeze command while a snapshot is pending is ignored. Freezing changes neither the waveform nor the access pattern.
- R10: Under low-then-high access a read pointer alternates between the low and high byte on each read of that channel. A control byte resets it to the low byte.
- R11: A read at address 3 returns 0. Channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (advances read pointer, releases snapshot) |
| addr | input | 2 | 0 to 2 select a channel count, 3 is the control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, combinational from addr |
| tick | input | 3 | Per-channel count enable |
| tmr_out | output | 3 | Per-channel waveform output |

## Verification
Two events can land on the same clock edge: a freeze command captures a channel's value, and a tick lowers that same count. The bench provokes this by raising channel 1's tick in the same cycle as a freeze command to that channel. The first read must then return the value before the decrement, and the next read must return the decremented live value. A wrong choice between the old and new count therefore shows up as an off-by-one byte in the scoreboard.

// File: rtl/tri_timer_pkg.sv
`timescale 1ns/100ps
package tri_timer_pkg;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'b00,
        ACC_LO     = 2'b01,
        ACC_HI     = 2'b10,
        ACC_BOTH   = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        MD_TERM   = 2'b00,
        MD_RATE   = 2'b01,
        MD_SQUARE = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_HALF  = 2'b01,
        ST_ARM   = 2'b10,
        ST_COUNT = 2'b11
    } chst_e;

    typedef struct packed {
        logic  cfg;
        logic  freeze;
        acc_e  acc;
        mode_e mode;
    } ctl_cmd_t;

    function automatic mode_e decode_mode(input logic [1:0] m);
        mode_e r;
        unique case (m)
            2'b10:   r = MD_RATE;
            2'b11:   r = MD_SQUARE;
            default: r = MD_TERM;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tri_timer_decode.sv
`timescale 1ns/100ps
module tri_timer_decode
    import tri_timer_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [BYTE_W-1:0]         wdata,
    output ctl_cmd_t [NCH-1:0]        cmd,
    output logic [NCH-1:0]            data_wr,
    output logic [NCH-1:0]            rd_hit
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NCH);

    logic       ctl_hit;
    logic [1:0] sel;
    acc_e       acc;

    assign ctl_hit = wr_en && (addr == CTL_ADDR);
    assign sel     = wdata[7:6];
    assign acc     = acc_e'(wdata[5:4]);

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        logic hit;
        assign hit             = ctl_hit && (sel == 2'(i));
        assign cmd[i].cfg      = hit && (acc != ACC_FREEZE);
        assign cmd[i].freeze   = hit && (acc == ACC_FREEZE);
        assign cmd[i].acc      = acc;
        assign cmd[i].mode     = decode_mode(wdata[2:1]);
        assign data_wr[i]      = wr_en && (addr == ADDR_W'(i));
        assign rd_hit[i]       = rd_en && (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/tri_timer_channel.sv
`timescale 1ns/100ps
module tri_timer_channel
    import tri_timer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ctl_cmd_t              cmd,
    input  logic                  data_wr,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  rd_hit,
    input  logic                  tick,
    output logic                  wave,
    output logic [BYTE_W-1:0]     rbyte,
    output mode_e                 mode_o,
    output logic                  run_o,
    output logic [2*BYTE_W-1:0]   cnt_o,
    output logic                  snap_vld_o,
    output logic [2*BYTE_W-1:0]   snap_o
);
    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    chst_e            state, state_nx;
    mode_e            mode;
    acc_e             acc;
    logic [CNT_W-1:0] reload, cnt, snap;
    logic             wptr, rptr, snap_vld;

    // Square-wave half lengths, zero taken as full range
    logic [CNT_W:0]   span, hlen, llen;
    logic [CNT_W-1:0] half_hi, half_lo;

    always_comb begin
        span    = (reload == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, reload};
        hlen    = (span + (CNT_W+1)'(1)) >> 1;
        llen    = span >> 1;
        half_hi = hlen[CNT_W-1:0];
        half_lo = (llen == '0) ? ONE : llen[CNT_W-1:0];
    end

    // Next-state logic: cfg_wr, lo_wr, done_wr, first_tick
    always_comb begin
        unique case (state)
            ST_IDLE, ST_HALF, ST_COUNT: state_nx = state;
            ST_ARM:                     state_nx = tick ? ST_COUNT : ST_ARM;
            default:                    state_nx = ST_IDLE;
        endcase
        if (data_wr)
            state_nx = (acc == ACC_BOTH && !wptr) ? ST_HALF : ST_ARM;
        if (cmd.cfg)
            state_nx = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath and output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MD_TERM;
            acc      <= ACC_BOTH;
            reload   <= '0;
            cnt      <= '0;
            wave     <= 1'b0;
            wptr     <= 1'b0;
            rptr     <= 1'b0;
            snap_vld <= 1'b0;
            snap     <= '0;
        end else begin
            if (tick && state == ST_ARM) begin
                cnt  <= (mode == MD_SQUARE) ? half_hi : reload;
                wave <= (mode != MD_TERM);
            end else if (tick && state == ST_COUNT) begin
                unique case (mode)
                    MD_RATE: begin
                        if (cnt == ONE) begin
                            cnt  <= reload;
                            wave <= 1'b0;
                        end else begin
                            cnt  <= cnt - ONE;
                            wave <= 1'b1;
                        end
                    end
                    MD_SQUARE: begin
                        if (cnt == ONE) begin
                            wave <= ~wave;
                            cnt  <= wave ? half_lo : half_hi;
                        end else begin
                            cnt  <= cnt - ONE;
                        end
                    end
                    default: begin
                        cnt <= cnt - ONE;
                        if (cnt == ONE) wave <= 1'b1;
                    end
                endcase
            end

            if (rd_hit) begin
                if (acc == ACC_BOTH) rptr <= ~rptr;
                if (snap_vld && (acc != ACC_BOTH || rptr)) snap_vld <= 1'b0;
            end

            if (cmd.freeze && !snap_vld) begin
                snap     <= cnt;
                snap_vld <= 1'b1;
            end

            if (data_wr) begin
                unique case (acc)
                    ACC_HI: reload <= {wdata, {BYTE_W{1'b0}}};
                    ACC_BOTH: begin
                        if (!wptr) reload[BYTE_W-1:0]     <= wdata;
                        else       reload[CNT_W-1:BYTE_W] <= wdata;
                        wptr <= ~wptr;
                    end
                    default: reload <= {{BYTE_W{1'b0}}, wdata};
                endcase
                if (mode == MD_TERM) wave <= 1'b0;
            end

            if (cmd.cfg) begin
                mode     <= cmd.mode;
                acc      <= cmd.acc;
                wptr     <= 1'b0;
                rptr     <= 1'b0;
                snap_vld <= 1'b0;
                wave     <= (cmd.mode != MD_TERM);
            end
        end
    end

    // Read byte selection
    logic [CNT_W-1:0] src;
    always_comb begin
        src = snap_vld ? snap : cnt;
        unique case (acc)
            ACC_HI:   rbyte = src[CNT_W-1:BYTE_W];
            ACC_BOTH: rbyte = rptr ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
            default:  rbyte = src[BYTE_W-1:0];
        endcase
    end

    assign mode_o     = mode;
    assign run_o      = (state == ST_COUNT);
    assign cnt_o      = cnt;
    assign snap_vld_o = snap_vld;
    assign snap_o     = snap;

endmodule

// File: rtl/tri_interval_timer.sv
`timescale 1ns/100ps
module tri_interval_timer
    import tri_timer_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [NCH-1:0]    tick,
    output logic [NCH-1:0]    tmr_out
);
    localparam int CNT_W = 2 * BYTE_W;

    ctl_cmd_t [NCH-1:0]            cmd;
    logic [NCH-1:0]                data_wr, rd_hit;
    logic [NCH-1:0][BYTE_W-1:0]    rbyte;
    mode_e [NCH-1:0]               mode_all;
    logic [NCH-1:0]                run_all, snapv_all;
    logic [NCH-1:0][CNT_W-1:0]     cnt_all, snap_all;

    tri_timer_decode #(.NCH(NCH), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .cmd     (cmd),
        .data_wr (data_wr),
        .rd_hit  (rd_hit)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tri_timer_channel #(.BYTE_W(BYTE_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd        (cmd[i]),
            .data_wr    (data_wr[i]),
            .wdata      (wdata),
            .rd_hit     (rd_hit[i]),
            .tick       (tick[i]),
            .wave       (tmr_out[i]),
            .rbyte      (rbyte[i]),
            .mode_o     (mode_all[i]),
            .run_o      (run_all[i]),
            .cnt_o      (cnt_all[i]),
            .snap_vld_o (snapv_all[i]),
            .snap_o     (snap_all[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (addr == ADDR_W'(i)) rdata = rbyte[i];
    end

endmodule

// File: rtl/tri_timer_checker.sv
`timescale 1ns/100ps
module tri_timer_checker
    import tri_timer_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic                      rd_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [BYTE_W-1:0]         rdata,
    input logic [NCH-1:0]            tick,
    input logic [NCH-1:0]            tmr_out,
    input mode_e [NCH-1:0]           mode_all,
    input logic [NCH-1:0]            run_all,
    input logic [NCH-1:0]            snapv_all,
    input logic [NCH-1:0][CNT_W-1:0] cnt_all,
    input logic [NCH-1:0][CNT_W-1:0] snap_all
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NCH);

    a_r11_ctl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CTL_ADDR) |-> (rdata == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick[i] && !wr_en) |=> $stable(cnt_all[i]));

        a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick[i] && !wr_en) |=> $stable(tmr_out[i]));

        a_r5_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_all[i] == MD_TERM && run_all[i] && tmr_out[i] && !wr_en) |=> tmr_out[i]);

        a_r6_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_all[i] == MD_RATE && run_all[i] && !tmr_out[i] && tick[i] && !wr_en
             && cnt_all[i] != CNT_W'(1)) |=> tmr_out[i]);

        a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (snapv_all[i] && !wr_en) |=> $stable(snap_all[i]));
    end

endmodule

bind tri_interval_timer tri_timer_checker #(
    .NCH(NCH), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .tick      (tick),
    .tmr_out   (tmr_out),
    .mode_all  (mode_all),
    .run_all   (run_all),
    .snapv_all (snapv_all),
    .cnt_all   (cnt_all),
    .snap_all  (snap_all)
);

// File: tb/tri_interval_timer_bench.sv
`timescale 1ns/100ps
module tri_interval_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] tick = '0;
    logic [2:0] tmr_out;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb_q[$];
    event sample_ev;

    always #2.5 clk = ~clk;

    tri_interval_timer u_tri_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .tmr_out(tmr_out)
    );

    // Monitor: pops expected read bytes and compares
    always @(sample_ev) begin : mon
        exp_t e;
        n_checks++;
        if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard empty: rdata=%02h expected none", rdata);
        end else begin
            e = sb_q.pop_front();
            if (rdata !== e.val) begin
                n_fail++;
                $display("FAIL %s: rdata=%02h expected %02h", e.tag, rdata, e.val);
            end
        end
    end

    task automatic chk_out(input int ch, input logic exp, input string tag);
        n_checks++;
        if (tmr_out[ch] !== exp) begin
            n_fail++;
            $display("FAIL %s: tmr_out[%0d]=%b expected %b", tag, ch, tmr_out[ch], exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        sb_q.push_back('{e, tag});
        #1;
        -> sample_ev;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_ticks(input int ch, input int n);
        @(negedge clk);
        tick[ch] = 1'b1;
        repeat (n) @(negedge clk);
        tick[ch] = 1'b0;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < 3; c++) chk_out(c, 1'b0, "R1 reset out");
        rd(0, 8'h00, "R1 ch0 lo");
        rd(0, 8'h00, "R1 ch0 hi");
        rd(1, 8'h00, "R1 ch1");
        rd(2, 8'h00, "R1 ch2");
        rd(3, 8'h00, "R11 ctl port read");

        // R5 terminal count, ch0, low-then-high, N=5
        wr(3, 8'h30);
        chk_out(0, 1'b0, "R5 low at control");
        wr(0, 8'h05);
        wr(0, 8'h00);
        rd(0, 8'h00, "R3 not loaded before tick lo");
        rd(0, 8'h00, "R3 not loaded before tick hi");
        run_ticks(0, 1);
        rd(0, 8'h05, "R4 load tick lo");
        rd(0, 8'h00, "R4 load tick hi");
        chk_out(0, 1'b0, "R5 low after load");
        run_ticks(0, 4);
        chk_out(0, 1'b0, "R5 low at count 1");
        run_ticks(0, 1);
        chk_out(0, 1'b1, "R5 high at terminal");
        run_ticks(0, 3);
        chk_out(0, 1'b1, "R5 stays high");

        // R9 freeze: live FFFD, second freeze ignored
        wr(3, 8'h00);
        run_ticks(0, 2);
        wr(3, 8'h00);
        run_ticks(0, 8);
        rd(0, 8'hFD, "R9 snapshot lo");
        rd(0, 8'hFF, "R9 snapshot hi");
        rd(0, 8'hF3, "R9 live lo");
        rd(0, 8'hFF, "R9 live hi");
        chk_out(0, 1'b1, "R9 waveform untouched");

        // R6 strobe, ch1, low only, N=4
        wr(3, 8'h54);
        chk_out(1, 1'b1, "R6 high at control");
        wr(1, 8'h04);
        run_ticks(1, 1);
        run_ticks(1, 3);
        rd(1, 8'h01, "R6 count 1");
        chk_out(1, 1'b1, "R6 high before strobe");
        run_ticks(1, 1);
        chk_out(1, 1'b0, "R6 strobe low");
        rd(1, 8'h04, "R6 reload");
        run_ticks(1, 1);
        chk_out(1, 1'b1, "R6 strobe one tick");
        rd(1, 8'h03, "R6 count after strobe");
        run_ticks(1, 3);
        chk_out(1, 1'b0, "R6 period 4");
        rd(0, 8'hF3, "R11 ch0 independent lo");
        rd(0, 8'hFF, "R11 ch0 independent hi");

        // R3 high only, ch2
        wr(3, 8'hA0);
        wr(2, 8'h01);
        run_ticks(2, 1);
        rd(2, 8'h01, "R3 high-only load");
        run_ticks(2, 1);
        rd(2, 8'h00, "R3 high-only after tick");

        // R2 BCD bit ignored, ch1, low only, 0x10 -> 0x0F
        wr(3, 8'h51);
        chk_out(1, 1'b0, "R2 terminal mode out low");
        wr(1, 8'h10);
        run_ticks(1, 1);
        run_ticks(1, 1);
        rd(1, 8'h0F, "R2 binary decrement");

        // R9 freeze in the same cycle as a tick on ch1 (count 0x0F)
        @(negedge clk);
        tick[1] = 1'b1; wr_en = 1'b1; addr = 2'd3; wdata = 8'h40;
        @(negedge clk);
        tick[1] = 1'b0; wr_en = 1'b0;
        rd(1, 8'h0F, "R9 freeze with tick, pre-edge value");
        rd(1, 8'h0E, "R9 live after release");

        // R7 square wave, ch2, N=5
        wr(3, 8'hB6);
        chk_out(2, 1'b1, "R7 high at control");
        wr(2, 8'h05);
        wr(2, 8'h00);
        run_ticks(2, 1);
        run_ticks(2, 2);
        chk_out(2, 1'b1, "R7 high half 3 ticks");
        run_ticks(2, 1);
        chk_out(2, 1'b0, "R7 low after 3");
        run_ticks(2, 1);
        chk_out(2, 1'b0, "R7 low half");
        run_ticks(2, 1);
        chk_out(2, 1'b1, "R7 high after low 2");

        // R2 select 3 ignored
        wr(3, 8'hF0);
        run_ticks(2, 2);
        chk_out(2, 1'b1, "R2 select 3 ignored");
        chk_out(0, 1'b1, "R2 select 3 ch0 untouched");

        // R10 pointer and halt, ch0
        wr(3, 8'h30);
        wr(0, 8'h34);
        run_ticks(0, 3);
        wr(0, 8'h12);
        run_ticks(0, 1);
        rd(0, 8'h34, "R10 first read lo");
        wr(3, 8'h30);
        run_ticks(0, 5);
        rd(0, 8'h34, "R10 pointer reset lo");
        rd(0, 8'h12, "R4 halted hi");

        // R8 zero count = 65536
        wr(3, 8'h30);
        wr(0, 8'h00);
        wr(0, 8'h00);
        run_ticks(0, 1);
        run_ticks(0, 65535);
        chk_out(0, 1'b0, "R8 low at 65535");
        run_ticks(0, 1);
        chk_out(0, 1'b1, "R8 high at 65536");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule